// File: doc/BRIEF.md
# Framed serial register port

This block is the slave side of a four-wire serial link into a converter's register file. A host lowers the frame strobe, clocks exactly sixteen bits in on the data input, and reads sixteen bits back on the data output during the same frame. The two leading bits of every incoming word name a register group. The remaining fourteen bits are committed only when the sixteenth bit has arrived. A frame that stops early changes nothing.

Reads carry no address of their own. A two-bit read pointer inside the control register picks the returned register, and it keeps that value until a later control write changes it. The control register also holds the channel, power, calibration and start fields that drive the rest of the converter. Two of those bits clear themselves when the converter signals completion. The alternate-interface bit clears itself after every complete frame that does not rewrite it. A bank of calibration registers is reached through an index. The calibration-select field sets this index, and each calibration access steps it by one.

All serial inputs are brought into the system clock domain through synchronisers and edge detectors. The serial clock must therefore run well below the system clock.

Top module: `sreg_port`

## Requirements
- R1: DIN is sampled MSB first on each detected SCLK rise. The top two bits of a frame select the target: 11 the control register, 01 the test register, 10 the calibration register at the current index, 00 nothing, and the 14 data bits of a 00 frame are discarded.
- R2: A register is written only once the sixteenth bit of a frame has been received. A frame ended early by SYNC rising leaves every register unchanged.
- R3: Control bits map, from data bit 13 down to 0, to: single-ended select, channel (3 bits), power mode (2), read pointer (2), alternate interface, software convert, system-calibration mode, calibration select (2), calibration start. Each field appears on its own output.
- R4: After reset all control bits are 0, DOUT and the driver enable are low, and reads return conversion data.
- R5: The read pointer at frame start picks the returned word: 00 gives four zeros then the 12-bit ADC result, 01 gives 01 then the test register, 10 gives 10 then the indexed calibration register, 11 gives 11 then the status input.
- R6: The returned word is captured when SYNC falls and is shifted out MSB first, one bit after each SCLK fall that follows a rise. The driver enable is high exactly while a frame is open.
- R7: Every complete frame that does not address the control register clears the alternate-interface bit.
- R8: A conversion-done pulse clears the software-convert bit, and a calibration-done pulse clears the calibration-start bit.
- R9: A control write with calibration start at 0 sets the calibration index to floor(sel*CAL_REGS/4), where sel is the calibration-select field; with 10 registers this gives 0, 2, 5 and 7. Otherwise, each complete frame that writes group 10 or is read with pointer 10 advances the index by one, wrapping from CAL_REGS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial bit clock from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | Driver enable for dout (high while a frame is open) |
| adc_data | input | DATA_W | Latest conversion result |
| status_in | input | 14 | Status word returned under read pointer 11 |
| conv_done | input | 1 | Pulse: conversion finished |
| cal_done | input | 1 | Pulse: calibration finished |
| ctl_single_ended | output | 1 | Input configuration select |
| ctl_channel | output | 3 | Channel number |
| ctl_power | output | 2 | Power-management mode |
| ctl_read_sel | output | 2 | Read pointer |
| ctl_alt_iface | output | 1 | Alternate-interface request |
| ctl_soft_convert | output | 1 | Software conversion start |
| ctl_cal_system | output | 1 | System (1) or self (0) calibration |
| ctl_cal_sel | output | 2 | Calibration type / register pointer |
| ctl_cal_start | output | 1 | Calibration start |

## Verification
On every cycle, the embedded properties check the following. The bit counter never passes the frame length. A commit strobe lasts one cycle. The control register holds still unless a commit or a done pulse arrives. A null-group frame never touches the test register. Any non-control commit drops the alternate-interface bit. A done pulse clears its bit. The calibration index stays inside the bank. Only the bench scenarios can show end-to-end effects. These include the returned word under each read pointer, with its read-before-write order inside one frame, and the index stepping, reloading and wrapping across many frames. They also include a truncated frame having no effect and the bit-level field mapping.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int FRAME_W = 16;
   localparam int REG_W   = 14;

   typedef enum logic [1:0] {
      GRP_NONE = 2'b00,
      GRP_TEST = 2'b01,
      GRP_CAL  = 2'b10,
      GRP_CTL  = 2'b11
   } grp_e;

   localparam logic [1:0] RD_ADC  = 2'b00;
   localparam logic [1:0] RD_TEST = 2'b01;
   localparam logic [1:0] RD_CAL  = 2'b10;
   localparam logic [1:0] RD_STAT = 2'b11;

   typedef struct packed {
      logic       single_ended;
      logic [2:0] channel;
      logic [1:0] power;
      logic [1:0] read_sel;
      logic       alt_iface;
      logic       soft_convert;
      logic       cal_system;
      logic [1:0] cal_sel;
      logic       cal_start;
   } ctl_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int STAGES = 2,
   parameter bit INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise,
   output logic fall
);
   // pipe[STAGES] holds the previous synchronised level for edge detection
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES + 1){INIT}};
      else        pipe <= {pipe[STAGES-1:0], d};
   end

   assign q    = pipe[STAGES-1];
   assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
   assign fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
   import sreg_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               frame_active,
   input  logic               sclk_rise,
   input  logic               sclk_fall,
   input  logic               din_s,
   input  logic [FRAME_W-1:0] rd_word,
   output logic               dout,
   output logic               wr_stb,
   output logic [FRAME_W-1:0] wr_word
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] rx_q, tx_q;
   logic               seen_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         seen_rise <= 1'b0;
         wr_stb    <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (frame_start) begin
            bit_cnt   <= '0;
            tx_q      <= rd_word;
            seen_rise <= 1'b0;
         end else if (frame_active) begin
            if (sclk_rise && bit_cnt != CNT_W'(FRAME_W)) begin
               rx_q      <= {rx_q[FRAME_W-2:0], din_s};
               bit_cnt   <= bit_cnt + 1'b1;
               seen_rise <= 1'b1;
               if (bit_cnt == CNT_W'(FRAME_W - 1)) wr_stb <= 1'b1;
            end
            if (sclk_fall && seen_rise) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign wr_word = rx_q;
   assign dout    = frame_active & tx_q[FRAME_W-1];

   AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W)); // R2
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R2
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
   import sreg_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int CAL_REGS = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb,
   input  logic [FRAME_W-1:0] wr_word,
   input  logic [DATA_W-1:0]  adc_data,
   input  logic [REG_W-1:0]   status_in,
   input  logic               conv_done,
   input  logic               cal_done,
   output ctl_t               ctl,
   output logic [FRAME_W-1:0] rd_word
);
   localparam int IDX_W = (CAL_REGS > 1) ? $clog2(CAL_REGS) : 1;
   localparam int PAD_W = FRAME_W - DATA_W;

   ctl_t             ctl_q;
   logic [REG_W-1:0] test_q;
   logic [IDX_W-1:0] cal_idx;
   logic [REG_W-1:0] cal_view [CAL_REGS];
   logic [REG_W-1:0] cal_rd;
   grp_e             grp;
   logic [REG_W-1:0] wdata;

   assign grp   = grp_e'(wr_word[FRAME_W-1 -: 2]);
   assign wdata = wr_word[REG_W-1:0];

   function automatic logic [IDX_W-1:0] idx_base(input logic [1:0] sel);
      return IDX_W'((int'(sel) * CAL_REGS) / 4);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         test_q  <= '0;
         cal_idx <= '0;
      end else begin
         if (conv_done) ctl_q.soft_convert <= 1'b0;
         if (cal_done)  ctl_q.cal_start    <= 1'b0;
         if (wr_stb) begin
            if (grp == GRP_CTL) ctl_q <= ctl_t'(wdata);
            else                ctl_q.alt_iface <= 1'b0;
            if (grp == GRP_TEST) test_q <= wdata;
            if (grp == GRP_CTL && !wdata[0])
               cal_idx <= idx_base(wdata[2:1]);
            else if (grp == GRP_CAL || ctl_q.read_sel == RD_CAL)
               cal_idx <= (cal_idx == IDX_W'(CAL_REGS - 1)) ? '0 : cal_idx + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < CAL_REGS; i++) begin : g_cal
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (wr_stb && grp == GRP_CAL && cal_idx == IDX_W'(i)) q <= wdata;
      end
      assign cal_view[i] = q;
   end

   always_comb begin
      cal_rd = '0;
      for (int i = 0; i < CAL_REGS; i++)
         if (cal_idx == IDX_W'(i)) cal_rd = cal_view[i];
   end

   always_comb begin
      unique case (ctl_q.read_sel)
         RD_ADC:  rd_word = {{PAD_W{1'b0}}, adc_data};
         RD_TEST: rd_word = {RD_TEST, test_q};
         RD_CAL:  rd_word = {RD_CAL, cal_rd};
         default: rd_word = {RD_STAT, status_in};
      endcase
   end

   assign ctl = ctl_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb && !conv_done && !cal_done |=> $stable(ctl_q)); // R2
   AST_NULL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && wr_word[FRAME_W-1 -: 2] == 2'b00 |=> $stable(test_q)); // R1
   AST_IFACE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && wr_word[FRAME_W-1 -: 2] != 2'b11 |=> !ctl_q.alt_iface); // R7
   AST_CONV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done && !wr_stb |=> !ctl_q.soft_convert); // R8
   AST_CALDONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done && !wr_stb |=> !ctl_q.cal_start); // R8
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cal_idx <= IDX_W'(CAL_REGS - 1)); // R9
endmodule

// File: rtl/sreg_port.sv
module sreg_port
   import sreg_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int CAL_REGS    = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic              sclk,
   input  logic              din,
   output logic              dout,
   output logic              dout_en,
   input  logic [DATA_W-1:0] adc_data,
   input  logic [13:0]       status_in,
   input  logic              conv_done,
   input  logic              cal_done,
   output logic              ctl_single_ended,
   output logic [2:0]        ctl_channel,
   output logic [1:0]        ctl_power,
   output logic [1:0]        ctl_read_sel,
   output logic              ctl_alt_iface,
   output logic              ctl_soft_convert,
   output logic              ctl_cal_system,
   output logic [1:0]        ctl_cal_sel,
   output logic              ctl_cal_start
);
   if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_data_w
      $error("sreg_port: DATA_W must lie in 1..14");
   end
   if (CAL_REGS < 4 || CAL_REGS > 64) begin : g_bad_cal_regs
      $error("sreg_port: CAL_REGS must lie in 4..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sreg_port: SYNC_STAGES must be at least 2");
   end

   logic sync_s, sync_rise_unused, frame_start;
   logic sclk_s_unused, sclk_rise, sclk_fall;
   logic din_s, din_rise_unused, din_fall_unused;
   logic frame_active, wr_stb;
   logic [FRAME_W-1:0] rd_word, wr_word;
   ctl_t ctl;

   sreg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_fs (
      .clk(clk), .rst_n(rst_n), .d(sync_n),
      .q(sync_s), .rise(sync_rise_unused), .fall(frame_start));
   sreg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_ck (
      .clk(clk), .rst_n(rst_n), .d(sclk),
      .q(sclk_s_unused), .rise(sclk_rise), .fall(sclk_fall));
   sreg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_di (
      .clk(clk), .rst_n(rst_n), .d(din),
      .q(din_s), .rise(din_rise_unused), .fall(din_fall_unused));

   assign frame_active = ~sync_s;
   assign dout_en      = frame_active;

   sreg_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .frame_active(frame_active), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .din_s(din_s), .rd_word(rd_word), .dout(dout),
      .wr_stb(wr_stb), .wr_word(wr_word));

   sreg_regs #(.DATA_W(DATA_W), .CAL_REGS(CAL_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word),
      .adc_data(adc_data), .status_in(status_in),
      .conv_done(conv_done), .cal_done(cal_done),
      .ctl(ctl), .rd_word(rd_word));

   assign ctl_single_ended = ctl.single_ended;
   assign ctl_channel      = ctl.channel;
   assign ctl_power        = ctl.power;
   assign ctl_read_sel     = ctl.read_sel;
   assign ctl_alt_iface    = ctl.alt_iface;
   assign ctl_soft_convert = ctl.soft_convert;
   assign ctl_cal_system   = ctl.cal_system;
   assign ctl_cal_sel      = ctl.cal_sel;
   assign ctl_cal_start    = ctl.cal_start;

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> !dout); // R6
endmodule

// File: tb/sreg_port_bench.sv
module sreg_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_n = 1'b1, sclk = 1'b0, din = 1'b0;
   logic        dout, dout_en;
   logic [11:0] adc_data = 12'hA5C;
   logic [13:0] status_in = 14'h1234;
   logic        conv_done = 1'b0, cal_done = 1'b0;
   logic        c_se, c_alt, c_conv, c_csys, c_cstart;
   logic [2:0]  c_ch;
   logic [1:0]  c_pwr, c_rd, c_csel;
   int          n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   sreg_port u_sreg_port (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
      .dout(dout), .dout_en(dout_en), .adc_data(adc_data), .status_in(status_in),
      .conv_done(conv_done), .cal_done(cal_done),
      .ctl_single_ended(c_se), .ctl_channel(c_ch), .ctl_power(c_pwr),
      .ctl_read_sel(c_rd), .ctl_alt_iface(c_alt), .ctl_soft_convert(c_conv),
      .ctl_cal_system(c_csys), .ctl_cal_sel(c_csel), .ctl_cal_start(c_cstart));

   // {word sent, word expected back in the same frame}
   localparam logic [31:0] VEC [22] = '{
      32'h6AB3_0A5C, 32'hC040_0A5C, 32'h0000_6AB3, 32'hF4C0_6AB3,
      32'h0000_D234, 32'hC080_D234, 32'h8111_8000, 32'h8222_8000,
      32'hC080_8000, 32'h0000_8111, 32'h0000_8222, 32'hC082_8000,
      32'h8333_8000, 32'hC082_8000, 32'h0000_8333, 32'hC086_8000,
      32'h8777_8000, 32'h8888_8000, 32'h8999_8000, 32'h0000_8111,
      32'hC000_8222, 32'h0000_0A5C};

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [13:0] ctl_now();
      return {c_se, c_ch, c_pwr, c_rd, c_alt, c_conv, c_csys, c_csel, c_cstart};
   endfunction

   task automatic xfer(input logic [15:0] w, input int nbits,
                       output logic [15:0] got, output logic en_ok);
      got = '0;
      en_ok = 1'b1;
      @(negedge clk);
      sync_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int b = 0; b < nbits; b++) begin
         din = w[15-b];
         repeat (5) @(negedge clk);
         got[15-b] = dout;
         if (!dout_en) en_ok = 1'b0;
         sclk = 1'b1;
         repeat (5) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (5) @(negedge clk);
      sync_n = 1'b1;
      repeat (6) @(negedge clk);
      if (dout_en !== 1'b0) en_ok = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] got;
      logic        en_ok;
      repeat (3) @(negedge clk);
      // R4: reset state
      chk("R4 control after reset", {2'b00, ctl_now()}, 16'h0000);
      chk("R4 dout idle", {14'b0, dout_en, dout}, 16'h0000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 R5 R6 R9: table walk
      for (int i = 0; i < 22; i++) begin
         xfer(VEC[i][31:16], 16, got, en_ok);
         chk($sformatf("R5 R9 vector %0d read word", i), got, VEC[i][15:0]);
         chk($sformatf("R6 vector %0d driver enable", i), {15'b0, en_ok}, 16'h0001);
      end

      // R2: truncated control frame has no effect
      xfer(16'hFFFF, 10, got, en_ok);
      chk("R2 partial frame control", {2'b00, ctl_now()}, 16'h0000);
      xfer(16'h0000, 16, got, en_ok);
      chk("R2 read pointer after partial", got, 16'h0A5C);

      // R3: field map
      xfer(16'hEAB5, 16, got, en_ok);
      chk("R3 single-ended", {15'b0, c_se}, 16'h1);
      chk("R3 channel", {13'b0, c_ch}, 16'h2);
      chk("R3 power", {14'b0, c_pwr}, 16'h2);
      chk("R3 read pointer", {14'b0, c_rd}, 16'h2);
      chk("R3 low flags", {10'b0, c_alt, c_conv, c_csys, c_csel, c_cstart}, 16'h0035);

      // R8: self clearing on done pulses
      @(negedge clk); conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
      @(negedge clk);
      chk("R8 convert cleared", {15'b0, c_conv}, 16'h0);
      chk("R8 cal start kept", {15'b0, c_cstart}, 16'h1);
      @(negedge clk); cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
      @(negedge clk);
      chk("R8 cal start cleared", {15'b0, c_cstart}, 16'h0);
      chk("R7 alt iface held without frame", {15'b0, c_alt}, 16'h1);

      // R7: null frame clears alternate interface only
      xfer(16'h0000, 16, got, en_ok);
      chk("R9 index kept by start=1 write", got, 16'h8111);
      chk("R7 alt iface cleared", {15'b0, c_alt}, 16'h0);
      chk("R7 other fields kept", {2'b00, ctl_now()}, 16'h2A84);

      // R1: null group data ignored
      xfer(16'hC040, 16, got, en_ok);
      chk("R9 index advanced by read", got, 16'h8222);
      xfer(16'h3FFF, 16, got, en_ok);
      chk("R1 test readback", got, 16'h6AB3);
      xfer(16'h0000, 16, got, en_ok);
      chk("R1 null group discarded", got, 16'h6AB3);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule